// File: doc/BRIEF.md
# Fixed-Period Fan PWM Generator

This block drives a two-wire fan with one active-high pulse-width-modulated output. The period is fixed at 40 ms. The hardware derives the number of clock cycles in one period from a clock-frequency parameter. Software sets the pulse width through an 8-bit duty field, where 255 means fully on, and starts or stops the output with an enable bit. A second register stores a 16-bit maximum fan speed value that software can read back. This value does not change the waveform.

Software reaches both registers through a plain word-wide read/write port. Reads are combinational from the address. Writes take effect at the clock edge on which the select and write strobes are both high. A new duty value is used in the very next cycle. Because of this, the period in which a write lands can mix the old and new widths. Clearing the enable bit drives the output low and forgets the position in the period. Setting it again starts a fresh period.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: One PWM period lasts CLK_HZ/25 clock cycles (40 ms). While enabled, the pattern repeats with exactly that spacing.
- R2: With duty value D, the output is high at the start of each period for ceil(D*P/255) cycles and low for the rest of the period, where P is the period length in cycles.
- R3: Duty 0 keeps the output low for the whole period. Duty 255 keeps it high for the whole period.
- R4: The control register is at byte offset 0x0. Bit 0 is the enable. Bits 23:16 are the duty. Bit 1 is the mode field, which always reads 0 (two-wire) and ignores writes. All other bits read 0.
- R5: The speed register is at byte offset 0x4. Bits 15:0 store the written value and read it back. Bits 31:16 read 0.
- R6: A read from any address other than 0x0 or 0x4 returns 0. A write to such an address changes no register.
- R7: While the enable bit is 0, the output is 0 and the period position is cleared. Setting the enable bit starts a period from count zero on the next cycle.
- R8: A new duty value changes the output compare on the cycle after the write, without waiting for the period boundary. The next full period follows the new value exactly.
- R9: After a synchronous reset, both registers read 0 and the output is low.
- R10: A write happens only when the select and write-enable strobes are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fan_pwm | output | 1 | Active-high PWM output to the fan |

## Verification
The bench shrinks the clock parameter so that a period is 510 cycles. With that period, every duty value D gives exactly 2*D high cycles. It measures whole-period high counts for duties 0, 1, 128 and 255. The two extreme duties separate a stuck or inverted compare from the normal case. Duty 1 shows the exact period length and that the high time comes at the start of the period. The bench also changes the duty mid-period, once upward and once downward. This tells an immediate update apart from one latched at the boundary. A disable and re-enable mid-period tells a cleared counter apart from one that resumes. A cycle-by-cycle behavioural model checks the output throughout.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

    localparam int WORD_W    = 32;
    localparam int DUTY_W    = 8;
    localparam int SPEED_W   = 16;
    localparam int DUTY_FULL = 255;

    // register byte offsets and field positions decoded by software
    localparam logic [31:0] OFS_CTRL  = 32'h0;
    localparam logic [31:0] OFS_SPEED = 32'h4;
    localparam int BIT_EN    = 0;
    localparam int BIT_MODE  = 1;
    localparam int DUTY_LSB  = 16;

    // 40 ms equals one 25th of a second
    localparam int PERIODS_PER_SEC = 25;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [DUTY_W-1:0]  duty_t;
    typedef logic [SPEED_W-1:0] speed_t;

    typedef enum logic {
        MODE_TWO_WIRE = 1'b0
    } fan_mode_e;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_CTRL,
        REG_SPEED
    } reg_sel_e;

    typedef struct packed {
        logic  en;
        duty_t duty;
    } ctrl_t;

    function automatic int period_cycles(input longint clk_hz);
        return int'(clk_hz / PERIODS_PER_SEC);
    endfunction

    function automatic word_t ctrl_to_word(input ctrl_t c);
        word_t w;
        w = '0;
        w[BIT_EN]               = c.en;
        w[BIT_MODE]             = MODE_TWO_WIRE;
        w[DUTY_LSB +: DUTY_W]   = c.duty;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input word_t w);
        ctrl_t c;
        c.en   = w[BIT_EN];
        c.duty = w[DUTY_LSB +: DUTY_W];
        return c;
    endfunction

    function automatic speed_t word_to_speed(input word_t w);
        return w[SPEED_W-1:0];
    endfunction

    function automatic word_t speed_to_word(input speed_t s);
        return {{(WORD_W-SPEED_W){1'b0}}, s};
    endfunction

endpackage

// File: rtl/fan_regfile.sv
module fan_regfile
    import fanpwm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output word_t             rdata,
    output ctrl_t             ctrl_q,
    output speed_t            speed_q
);

    reg_sel_e target;
    logic     wr_fire;

    always_comb begin
        if (addr == ADDR_W'(OFS_CTRL))       target = REG_CTRL;
        else if (addr == ADDR_W'(OFS_SPEED)) target = REG_SPEED;
        else                                 target = REG_NONE;
    end

    assign wr_fire = sel && we;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            speed_q <= '0;
        end else if (wr_fire) begin
            case (target)
                REG_CTRL:  ctrl_q  <= word_to_ctrl(wdata);
                REG_SPEED: speed_q <= word_to_speed(wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (target)
            REG_CTRL:  rdata = ctrl_to_word(ctrl_q);
            REG_SPEED: rdata = speed_to_word(speed_q);
            default:   rdata = '0;
        endcase
    end

    // R5
    speed_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && target == REG_SPEED) |=> (speed_q == $past(wdata[SPEED_W-1:0])));

    // R6
    bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && target == REG_NONE) |=> ($stable(ctrl_q) && $stable(speed_q)));

    // R10
    no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_fire |=> ($stable(ctrl_q) && $stable(speed_q)));

endmodule

// File: rtl/fan_period_ctr.sv
module fan_period_ctr #(
    parameter int PERIOD = 510,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    always_ff @(posedge clk) begin
        if (rst || !run)       cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + CNT_W'(1);
    end

    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == LAST) |=> (cnt == '0));

    // R1
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != LAST) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/fan_duty_cmp.sv
module fan_duty_cmp
    import fanpwm_pkg::*;
#(
    parameter int PERIOD = 510,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  duty_t            duty,
    output logic             pwm
);

    // cnt < duty*PERIOD/255  rewritten as  cnt*255 < duty*PERIOD
    localparam int PROD_W = CNT_W + DUTY_W + 2;

    logic [PROD_W-1:0] pos_scaled;
    logic [PROD_W-1:0] thr_scaled;

    assign pos_scaled = PROD_W'(cnt)  * PROD_W'(DUTY_FULL);
    assign thr_scaled = PROD_W'(duty) * PROD_W'(PERIOD);
    assign pwm        = run && (pos_scaled < thr_scaled);

endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
    import fanpwm_pkg::*;
#(
    parameter longint CLK_HZ = 100_000_000,
    parameter int     ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              fan_pwm
);

    localparam int PERIOD = period_cycles(CLK_HZ);
    localparam int CNT_W  = $clog2(PERIOD);

    ctrl_t            ctrl_q;
    speed_t           speed_q;
    logic [CNT_W-1:0] pos;

    fan_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (bus_sel),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .ctrl_q  (ctrl_q),
        .speed_q (speed_q)
    );

    fan_period_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_ctr (
        .clk (clk),
        .rst (rst),
        .run (ctrl_q.en),
        .cnt (pos)
    );

    fan_duty_cmp #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_cmp (
        .run  (ctrl_q.en),
        .cnt  (pos),
        .duty (ctrl_q.duty),
        .pwm  (fan_pwm)
    );

    // R7
    gate_low_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |-> !fan_pwm);

    // R3
    full_on_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && ctrl_q.duty == duty_t'(DUTY_FULL)) |-> fan_pwm);

    // R3
    zero_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.duty == '0) |-> !fan_pwm);

    // R2
    start_high_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && pos == '0 && ctrl_q.duty != '0) |-> fan_pwm);

    // R9
    reset_low_chk: assert property (@(posedge clk)
        rst |=> (!fan_pwm && bus_rdata == '0 || bus_addr != '0));

endmodule

// File: tb/sim_fan_pwm_ctrl.sv
module sim_fan_pwm_ctrl;

    localparam longint CLK_HZ = 12750;   // period = 510 cycles, high time = 2*duty
    localparam int     PER    = 510;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fan_pwm;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference
    bit  m_en = 0;
    int  m_duty = 0;
    int  m_cnt = 0;

    fan_pwm_ctrl #(.CLK_HZ(CLK_HZ), .ADDR_W(8)) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .fan_pwm   (fan_pwm)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_en <= 0; m_duty <= 0; m_cnt <= 0;
        end else begin
            if (m_en) m_cnt <= (m_cnt == PER - 1) ? 0 : m_cnt + 1;
            else      m_cnt <= 0;
            if (bus_sel && bus_we && bus_addr == 8'h00) begin
                m_en   <= bus_wdata[0];
                m_duty <= int'(bus_wdata[23:16]);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R2, R7, R8)
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            chk("R2 per-cycle output", {31'b0, fan_pwm},
                {31'b0, (m_en && (m_cnt < 2 * m_duty))});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic measure(input int n, output int hi, output bit first);
        hi = 0;
        first = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            if (i == 0) first = fan_pwm;
            if (fan_pwm) hi++;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input int d, input bit en);
        return {8'h00, 8'(d), 15'h0, en};
    endfunction

    initial begin
        int  hi;
        bit  first;
        bit  samp [0:519];
        int  duties [4] = '{0, 1, 128, 255};

        repeat (3) @(negedge clk);
        rst = 0;

        // R9 reset state
        rd(8'h00, 32'h0, "R9 control after reset");
        rd(8'h04, 32'h0, "R9 speed after reset");
        chk("R9 output after reset", {31'b0, fan_pwm}, 32'h0);

        // R5 speed register
        wr(8'h04, 32'hDEAD_0FA0);
        rd(8'h04, 32'h0000_0FA0, "R5 speed readback");

        // R4 layout, mode fixed to 0, unused bits zero
        wr(8'h00, 32'hFFFF_FFFE);
        rd(8'h00, 32'h00FF_0000, "R4 control readback");
        repeat (4) @(negedge clk);
        #1 chk("R7 disabled output low", {31'b0, fan_pwm}, 32'h0);

        // R6 unmapped addresses
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        rd(8'h08, 32'h0, "R6 unmapped read");
        rd(8'h04, 32'h0000_0FA0, "R6 speed untouched");
        rd(8'h00, 32'h00FF_0000, "R6 control untouched");

        // R10 write strobe without select
        bus_sel = 0; bus_we = 1; bus_addr = 8'h00; bus_wdata = 32'h0000_0001;
        @(posedge clk); @(negedge clk);
        bus_we = 0;
        rd(8'h00, 32'h00FF_0000, "R10 unselected write ignored");

        // R2 / R3 high time per duty
        foreach (duties[k]) begin
            wr(8'h00, 32'h0);
            wr(8'h00, ctrl_word(duties[k], 1'b1));
            measure(PER, hi, first);
            chk(duties[k] == 0 || duties[k] == 255 ? "R3 high count" : "R2 high count",
                32'(hi), 32'(2 * duties[k]));
            chk("R2 start-of-period level", {31'b0, first},
                {31'b0, (duties[k] != 0)});
        end

        // R1 period length with duty 1
        wr(8'h00, 32'h0);
        wr(8'h00, ctrl_word(1, 1'b1));
        for (int i = 0; i < 520; i++) begin
            #1 samp[i] = fan_pwm;
            @(negedge clk);
        end
        chk("R1 low before wrap", {31'b0, samp[509]}, 32'h0);
        chk("R1 high at wrap",    {31'b0, samp[510]}, 32'h1);
        chk("R1 second high",     {31'b0, samp[511]}, 32'h1);
        chk("R1 low after pulse", {31'b0, samp[512]}, 32'h0);

        // R8 duty raised mid-period
        wr(8'h00, 32'h0);
        wr(8'h00, ctrl_word(64, 1'b1));
        repeat (50) @(negedge clk);
        wr(8'h00, ctrl_word(200, 1'b1));
        measure(PER - 51, hi, first);
        chk("R8 mixed period rest", 32'(hi), 32'd349);
        measure(PER, hi, first);
        chk("R8 next full period", 32'(hi), 32'd400);

        // R8 duty lowered below current position
        repeat (300) @(negedge clk);
        #1 chk("R8 high before lowering", {31'b0, fan_pwm}, 32'h1);
        wr(8'h00, ctrl_word(100, 1'b1));
        #1 chk("R8 low right after lowering", {31'b0, fan_pwm}, 32'h0);

        // R7 disable mid-period and restart from zero
        wr(8'h00, ctrl_word(100, 1'b0));
        #1 chk("R7 output low when disabled", {31'b0, fan_pwm}, 32'h0);
        repeat (5) @(negedge clk);
        wr(8'h00, ctrl_word(100, 1'b1));
        measure(200, hi, first);
        chk("R7 fresh period high part", 32'(hi), 32'd200);
        measure(PER - 200, hi, first);
        chk("R7 fresh period low part", 32'(hi), 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule